// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block sits between the bus of a byte-wide NOR-style flash model and its embedded-algorithm engine. It watches single-cycle write strobes that carry an address and a data byte. It recognises the multi-write unlock sequences that start a program, a chip erase or a sector erase, an identifier read, or a suspend or resume of an erase. Recognised operations go to the engine as one-cycle registered start pulses, with the target address and data latched beside them. A two-bit mode output tells the read path whether reads return array data, identifier bytes or array data while an erase is suspended, or whether the device is busy.

Writes have no back-pressure. Every cycle with `wr_en` high is one complete bus write and is consumed at once. The engine reports the end of an operation with a one-cycle `eng_done` pulse. It holds `eng_fail` high while a running operation has exceeded its limits. A sector erase collects sectors for a programmable number of clock cycles after each load, and then starts by itself.

Top module: `flash_cmd_decoder`

## Requirements
- R1: After reset, `mode` is 0 (array read), `sect_mask` is 0, `window_open` is 0 and every pulse output is 0.
- R2: The writes AAh@555h, 55h@2AAh and A0h@555h, followed by a fourth write with any address and data, give `prog_start` high for the one cycle after the fourth write. In that cycle `prog_addr` and `prog_data` hold the fourth write, and `mode` becomes 3 (busy).
- R3: The writes AAh@555h, 55h@2AAh, 80h@555h, AAh@555h, 55h@2AAh and 10h@555h give `chip_erase_start` high for the one cycle after the sixth write, and `mode` becomes 3.
- R4: Command-cycle addresses are compared on the low 11 bits only. Upper address bits on unlock and code writes have no effect.
- R5: A write with a wrong address or data value inside a sequence, or a write out of order, returns `mode` to 0 and produces no pulse. That write is consumed and does not begin a new sequence. A write of F0h while no operation runs leaves `mode` at 0.
- R6: A sixth write of 30h at any address (the sector address) sets one bit of `sect_mask` and opens the load window (`window_open`=1, `mode`=3). Sectors are bits 0-6 for the 64 KB blocks at A18..A16 = 0-6, bit 7 for 70000h-77FFFh, bit 8 for 78000h-79FFFh, bit 9 for 7A000h-7BFFFh and bit 10 for 7C000h-7FFFFh. Each further 30h write within WIN_CYC cycles of the previous load adds its bit and restarts the window. After WIN_CYC write-free cycles, `sect_erase_start` pulses for one cycle and the window closes.
- R7: During the load window, a write of any code other than 30h or B0h returns `mode` to 0, clears `sect_mask` and starts no erase.
- R8: While a program or an erase runs, all writes are ignored, with two exceptions. During a sector erase, B0h gives `suspend_req` and `mode` 2. While `eng_fail` is high, F0h gives `abort_req` and leaves the busy state.
- R9: B0h during the load window gives `sect_erase_start` and `suspend_req` in the same cycle, and `mode` becomes 2.
- R10: While suspended, 30h gives `resume_req` and `mode` 3. A program sequence is accepted, and its `eng_done` returns `mode` to 2. All other writes leave `mode` at 2.
- R11: AAh@555h, 55h@2AAh, 90h@555h set `mode` to 1. `id_byte` is C2h for `rd_sel`=0, DEV_CODE for `rd_sel`=1 and 00h otherwise. F0h returns `mode` to 0.
- R12: `eng_done` ends a program, chip erase or sector erase and returns `mode` to 0 with `sect_mask` cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | One bus write this cycle |
| wr_addr | input | AW | Write address |
| wr_data | input | 8 | Write data |
| rd_sel | input | 2 | Low two read-address bits for identifier bytes |
| eng_done | input | 1 | Engine finished current operation (pulse) |
| eng_fail | input | 1 | Engine exceeded its limits (level) |
| prog_start | output | 1 | Start program pulse |
| prog_addr | output | AW | Latched program address |
| prog_data | output | 8 | Latched program data |
| chip_erase_start | output | 1 | Start chip erase pulse |
| sect_erase_start | output | 1 | Start sector erase pulse |
| sect_mask | output | 11 | Selected sectors, one bit each |
| suspend_req | output | 1 | Suspend erase pulse |
| resume_req | output | 1 | Resume erase pulse |
| abort_req | output | 1 | Abort failed operation pulse |
| window_open | output | 1 | Sector load window is open |
| mode | output | 2 | 0 array, 1 identifier, 2 suspended, 3 busy |
| id_byte | output | 8 | Identifier byte chosen by rd_sel |

## Verification
The sequences are driven with and without upper address bits on the unlock writes. This separates an 11-bit compare from a full-width one. A prefix broken at its second write shows that rejected writes do not restart a sequence. Sector loads at varied gaps below the window show restart-on-load against a fixed deadline. A load followed by 80h, and one followed by B0h, separate the reset path from the suspend-start path. Writes sent during program, chip erase, erase and suspension, with `eng_fail` both low and high, show which codes each state accepts.

// File: rtl/fcd_pkg.sv
package fcd_pkg;
  localparam int DW       = 8;
  localparam int CMP_BITS = 11;
  localparam int N_BIG    = 7;
  localparam int N_SECT   = 11;
  localparam int HI_BITS  = 6;

  localparam logic [CMP_BITS-1:0] ADR_A = 11'h555;
  localparam logic [CMP_BITS-1:0] ADR_B = 11'h2AA;
  localparam logic [DW-1:0] C_KEY1  = 8'hAA;
  localparam logic [DW-1:0] C_KEY2  = 8'h55;
  localparam logic [DW-1:0] C_PROG  = 8'hA0;
  localparam logic [DW-1:0] C_ERASE = 8'h80;
  localparam logic [DW-1:0] C_IDENT = 8'h90;
  localparam logic [DW-1:0] C_CHIP  = 8'h10;
  localparam logic [DW-1:0] C_SECT  = 8'h30;
  localparam logic [DW-1:0] C_SUSP  = 8'hB0;
  localparam logic [DW-1:0] C_RESET = 8'hF0;
  localparam logic [DW-1:0] C_MFR   = 8'hC2;

  typedef enum logic [3:0] {
    S_IDLE, S_U1, S_U2, S_PW, S_E0, S_E1, S_E2, S_SLOAD,
    S_PROG, S_CHIP, S_SERASE, S_SUSP, S_SU1, S_SU2, S_SPW, S_SPROG
  } seq_t;

  typedef enum logic [1:0] {
    MODE_ARRAY = 2'd0, MODE_ID = 2'd1, MODE_SUSP = 2'd2, MODE_BUSY = 2'd3
  } mode_t;

  typedef struct packed {
    logic key1;
    logic key2;
    logic at_cmd;
  } wcls_t;
endpackage

// File: rtl/fcd_cycle_match.sv
module fcd_cycle_match
  import fcd_pkg::*;
(
  input  logic [CMP_BITS-1:0] addr_lo,
  input  logic [DW-1:0]       data,
  output wcls_t               cls
);
  logic hit_a, hit_b;
  assign hit_a      = (addr_lo == ADR_A);
  assign hit_b      = (addr_lo == ADR_B);
  assign cls.at_cmd = hit_a;
  assign cls.key1   = hit_a && (data == C_KEY1);
  assign cls.key2   = hit_b && (data == C_KEY2);
endmodule

// File: rtl/fcd_sector_map.sv
module fcd_sector_map
  import fcd_pkg::*;
(
  input  logic [HI_BITS-1:0] hi,
  output logic [N_SECT-1:0]  hot
);
  logic top_blk;
  assign top_blk = (hi[5:3] == 3'd7);

  genvar g;
  generate
    for (g = 0; g < N_BIG; g++) begin : g_big
      assign hot[g] = (hi[5:3] == 3'(g));
    end
  endgenerate

  assign hot[N_BIG]   = top_blk && !hi[2];
  assign hot[N_BIG+1] = top_blk && hi[2] && !hi[1] && !hi[0];
  assign hot[N_BIG+2] = top_blk && hi[2] && !hi[1] && hi[0];
  assign hot[N_BIG+3] = top_blk && hi[2] && hi[1];
endmodule

// File: rtl/fcd_window_timer.sv
module fcd_window_timer #(
  parameter int WIN_CYC = 6000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic run,
  output logic expire
);
  localparam int CW = $clog2(WIN_CYC + 1);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)                      cnt <= '0;
    else if (load)                   cnt <= CW'(WIN_CYC);
    else if (run && cnt != '0)       cnt <= cnt - CW'(1);
  end

  assign expire = run && (cnt == CW'(1));
endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
  import fcd_pkg::*;
#(
  parameter int          AW       = 19,
  parameter int          WIN_CYC  = 6000,
  parameter logic [7:0]  DEV_CODE = 8'h45
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_addr,
  input  logic [7:0]        wr_data,
  input  logic [1:0]        rd_sel,
  input  logic              eng_done,
  input  logic              eng_fail,
  output logic              prog_start,
  output logic [AW-1:0]     prog_addr,
  output logic [7:0]        prog_data,
  output logic              chip_erase_start,
  output logic              sect_erase_start,
  output logic [N_SECT-1:0] sect_mask,
  output logic              suspend_req,
  output logic              resume_req,
  output logic              abort_req,
  output logic              window_open,
  output logic [1:0]        mode,
  output logic [7:0]        id_byte
);
  seq_t              st, st_n;
  logic              id_q, id_n;
  logic [N_SECT-1:0] mask_n;
  logic              ld, expire;
  logic              p_go, c_go, s_go, sus, res, abt;
  wcls_t             wc;
  logic [N_SECT-1:0] sect_hot;
  logic              rst_code, susp_code, sect_code;

  fcd_cycle_match u_match (
    .addr_lo (wr_addr[CMP_BITS-1:0]),
    .data    (wr_data),
    .cls     (wc)
  );

  fcd_sector_map u_map (
    .hi  (wr_addr[AW-1:AW-HI_BITS]),
    .hot (sect_hot)
  );

  fcd_window_timer #(.WIN_CYC(WIN_CYC)) u_win (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (ld),
    .run    (st == S_SLOAD),
    .expire (expire)
  );

  assign rst_code  = wr_en && (wr_data == C_RESET);
  assign susp_code = wr_en && (wr_data == C_SUSP);
  assign sect_code = wr_en && (wr_data == C_SECT);

  always_comb begin
    st_n   = st;
    id_n   = id_q;
    mask_n = sect_mask;
    ld     = 1'b0;
    p_go   = 1'b0;
    c_go   = 1'b0;
    s_go   = 1'b0;
    sus    = 1'b0;
    res    = 1'b0;
    abt    = 1'b0;
    case (st)
      S_IDLE: if (wr_en) begin
        if (wc.key1) st_n = S_U1;
        else         id_n = 1'b0;
      end
      S_U1: if (wr_en) begin
        if (wc.key2) st_n = S_U2;
        else begin st_n = S_IDLE; id_n = 1'b0; end
      end
      S_U2: if (wr_en) begin
        st_n = S_IDLE;
        id_n = 1'b0;
        if (wc.at_cmd) begin
          case (wr_data)
            C_PROG:  st_n = S_PW;
            C_ERASE: st_n = S_E0;
            C_IDENT: id_n = 1'b1;
            default: ;
          endcase
        end
      end
      S_PW: if (wr_en) begin p_go = 1'b1; st_n = S_PROG; end
      S_E0: if (wr_en) st_n = wc.key1 ? S_E1 : S_IDLE;
      S_E1: if (wr_en) st_n = wc.key2 ? S_E2 : S_IDLE;
      S_E2: if (wr_en) begin
        st_n = S_IDLE;
        if (wc.at_cmd && wr_data == C_CHIP) begin
          c_go = 1'b1;
          st_n = S_CHIP;
        end else if (sect_code) begin
          st_n   = S_SLOAD;
          mask_n = sect_hot;
          ld     = 1'b1;
        end
      end
      S_SLOAD: begin
        if (sect_code) begin
          mask_n = sect_mask | sect_hot;
          ld     = 1'b1;
        end else if (susp_code) begin
          s_go = 1'b1;
          sus  = 1'b1;
          st_n = S_SUSP;
        end else if (wr_en) begin
          st_n = S_IDLE;
        end else if (expire) begin
          s_go = 1'b1;
          st_n = S_SERASE;
        end
      end
      S_PROG, S_CHIP: begin
        if (eng_done) st_n = S_IDLE;
        else if (rst_code && eng_fail) begin abt = 1'b1; st_n = S_IDLE; end
      end
      S_SERASE: begin
        if (eng_done) st_n = S_IDLE;
        else if (susp_code) begin sus = 1'b1; st_n = S_SUSP; end
        else if (rst_code && eng_fail) begin abt = 1'b1; st_n = S_IDLE; end
      end
      S_SUSP: begin
        if (sect_code) begin res = 1'b1; st_n = S_SERASE; end
        else if (wr_en && wc.key1) st_n = S_SU1;
      end
      S_SU1: if (wr_en) st_n = wc.key2 ? S_SU2 : S_SUSP;
      S_SU2: if (wr_en) st_n = (wc.at_cmd && wr_data == C_PROG) ? S_SPW : S_SUSP;
      S_SPW: if (wr_en) begin p_go = 1'b1; st_n = S_SPROG; end
      S_SPROG: begin
        if (eng_done) st_n = S_SUSP;
        else if (rst_code && eng_fail) begin abt = 1'b1; st_n = S_SUSP; end
      end
      default: st_n = S_IDLE;
    endcase
    if (st_n == S_IDLE) mask_n = '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st               <= S_IDLE;
      id_q             <= 1'b0;
      sect_mask        <= '0;
      prog_start       <= 1'b0;
      chip_erase_start <= 1'b0;
      sect_erase_start <= 1'b0;
      suspend_req      <= 1'b0;
      resume_req       <= 1'b0;
      abort_req        <= 1'b0;
      prog_addr        <= '0;
      prog_data        <= '0;
    end else begin
      st               <= st_n;
      id_q             <= id_n;
      sect_mask        <= mask_n;
      prog_start       <= p_go;
      chip_erase_start <= c_go;
      sect_erase_start <= s_go;
      suspend_req      <= sus;
      resume_req       <= res;
      abort_req        <= abt;
      if (p_go) begin
        prog_addr <= wr_addr;
        prog_data <= wr_data;
      end
    end
  end

  always_comb begin
    case (st)
      S_IDLE, S_U1, S_U2:         mode = id_q ? MODE_ID : MODE_ARRAY;
      S_PW, S_E0, S_E1, S_E2:     mode = MODE_ARRAY;
      S_SUSP, S_SU1, S_SU2, S_SPW: mode = MODE_SUSP;
      default:                    mode = MODE_BUSY;
    endcase
  end

  assign window_open = (st == S_SLOAD);
  assign id_byte     = (rd_sel == 2'd0) ? C_MFR :
                       (rd_sel == 2'd1) ? DEV_CODE : 8'h00;
endmodule

// File: rtl/fcd_checker.sv
module fcd_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_en,
  input logic [7:0]  wr_data,
  input logic        eng_fail,
  input logic        prog_start,
  input logic        chip_erase_start,
  input logic        sect_erase_start,
  input logic [10:0] sect_mask,
  input logic        suspend_req,
  input logic        resume_req,
  input logic        abort_req,
  input logic        window_open,
  input logic [1:0]  mode
);
  a_r2_prog_after_write: assert property (@(posedge clk) disable iff (!rst_n)
    prog_start |-> $past(wr_en));

  a_r3_chip_needs_code: assert property (@(posedge clk) disable iff (!rst_n)
    chip_erase_start |-> ($past(wr_en) && $past(wr_data) == 8'h10));

  a_r6_single_start: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({prog_start, chip_erase_start, sect_erase_start}));

  a_r6_window_is_busy: assert property (@(posedge clk) disable iff (!rst_n)
    window_open |-> (mode == 2'd3));

  a_r6_mask_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd3 && !window_open && $past(mode == 2'd3 && !window_open))
      |-> $stable(sect_mask));

  a_r8_abort_needs_fail: assert property (@(posedge clk) disable iff (!rst_n)
    abort_req |-> ($past(eng_fail) && $past(wr_en) && $past(wr_data) == 8'hF0));

  a_r9_suspend_code: assert property (@(posedge clk) disable iff (!rst_n)
    suspend_req |-> ($past(wr_en) && $past(wr_data) == 8'hB0 && mode == 2'd2));

  a_r10_resume_from_susp: assert property (@(posedge clk) disable iff (!rst_n)
    resume_req |-> ($past(mode) == 2'd2 && mode == 2'd3));
endmodule

bind flash_cmd_decoder fcd_checker u_chk (
  .clk              (clk),
  .rst_n            (rst_n),
  .wr_en            (wr_en),
  .wr_data          (wr_data),
  .eng_fail         (eng_fail),
  .prog_start       (prog_start),
  .chip_erase_start (chip_erase_start),
  .sect_erase_start (sect_erase_start),
  .sect_mask        (sect_mask),
  .suspend_req      (suspend_req),
  .resume_req       (resume_req),
  .abort_req        (abort_req),
  .window_open      (window_open),
  .mode             (mode)
);

// File: tb/sim_flash_cmd_decoder.sv
`timescale 1ns/1ps
module sim_flash_cmd_decoder;
  localparam int W = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [18:0] wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic [1:0]  rd_sel = '0;
  logic        eng_done = 1'b0;
  logic        eng_fail = 1'b0;
  logic        prog_start, chip_erase_start, sect_erase_start;
  logic        suspend_req, resume_req, abort_req, window_open;
  logic [18:0] prog_addr;
  logic [7:0]  prog_data, id_byte;
  logic [10:0] sect_mask;
  logic [1:0]  mode;

  int n_tests = 0;
  int n_fail  = 0;
  bit done_flag = 0;

  always #2.5 clk = ~clk;

  flash_cmd_decoder #(.AW(19), .WIN_CYC(W), .DEV_CODE(8'h45)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_sel(rd_sel), .eng_done(eng_done), .eng_fail(eng_fail),
    .prog_start(prog_start), .prog_addr(prog_addr), .prog_data(prog_data),
    .chip_erase_start(chip_erase_start), .sect_erase_start(sect_erase_start),
    .sect_mask(sect_mask), .suspend_req(suspend_req), .resume_req(resume_req),
    .abort_req(abort_req), .window_open(window_open), .mode(mode), .id_byte(id_byte)
  );

  task automatic chk(input string tag, input string what, input longint act, input longint exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // Behavioural reference: phase numbers follow the command protocol steps.
  localparam int K_IDLE = 0, K_UNL1 = 1, K_UNL2 = 2, K_PDATA = 3, K_ER80 = 4,
                 K_ER4 = 5, K_ER5 = 6, K_LOAD = 7, K_PROG = 8, K_CHIP = 9,
                 K_ERASE = 10, K_SUSP = 11, K_SUN1 = 12, K_SUN2 = 13,
                 K_SPDATA = 14, K_SPROG = 15;
  int          ph;
  bit          m_id;
  int          m_mask;
  int          m_cnt;
  bit          e_p, e_c, e_s, e_su, e_re, e_ab;
  int          e_pa, e_pd;
  int          lo, dd;
  bit          w;

  function automatic int sect_of(input int a);
    if (a < 'h70000) return a / 'h10000;
    if (a < 'h78000) return 7;
    if (a < 'h7A000) return 8;
    if (a < 'h7C000) return 9;
    return 10;
  endfunction

  function automatic int exp_mode();
    if (ph == K_IDLE || ph == K_UNL1 || ph == K_UNL2) return m_id ? 1 : 0;
    if (ph >= K_PDATA && ph <= K_ER5) return 0;
    if (ph >= K_SUSP && ph <= K_SPDATA) return 2;
    return 3;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      ph = K_IDLE; m_id = 0; m_mask = 0; m_cnt = 0;
      e_p = 0; e_c = 0; e_s = 0; e_su = 0; e_re = 0; e_ab = 0; e_pa = 0; e_pd = 0;
    end else begin
      w  = wr_en;
      lo = int'(wr_addr) & 'h7FF;
      dd = int'(wr_data);
      e_p = 0; e_c = 0; e_s = 0; e_su = 0; e_re = 0; e_ab = 0;
      if (ph == K_PROG || ph == K_CHIP || ph == K_ERASE || ph == K_SPROG) begin
        if (eng_done) ph = (ph == K_SPROG) ? K_SUSP : K_IDLE;
        else if (w && ph == K_ERASE && dd == 'hB0) begin e_su = 1; ph = K_SUSP; end
        else if (w && dd == 'hF0 && eng_fail) begin
          e_ab = 1; ph = (ph == K_SPROG) ? K_SUSP : K_IDLE;
        end
      end else if (ph == K_LOAD) begin
        if (w && dd == 'h30) begin m_mask |= (1 << sect_of(int'(wr_addr))); m_cnt = W; end
        else if (w && dd == 'hB0) begin e_s = 1; e_su = 1; ph = K_SUSP; end
        else if (w) ph = K_IDLE;
        else if (m_cnt == 1) begin e_s = 1; ph = K_ERASE; end
        else m_cnt--;
      end else if (w) begin
        case (ph)
          K_IDLE:  if (lo == 'h555 && dd == 'hAA) ph = K_UNL1; else m_id = 0;
          K_UNL1:  if (lo == 'h2AA && dd == 'h55) ph = K_UNL2; else begin ph = K_IDLE; m_id = 0; end
          K_UNL2: begin
            ph = K_IDLE; m_id = 0;
            if (lo == 'h555 && dd == 'hA0) ph = K_PDATA;
            else if (lo == 'h555 && dd == 'h80) ph = K_ER80;
            else if (lo == 'h555 && dd == 'h90) m_id = 1;
          end
          K_PDATA, K_SPDATA: begin
            e_p = 1; e_pa = int'(wr_addr); e_pd = dd;
            ph = (ph == K_PDATA) ? K_PROG : K_SPROG;
          end
          K_ER80: ph = (lo == 'h555 && dd == 'hAA) ? K_ER4 : K_IDLE;
          K_ER4:  ph = (lo == 'h2AA && dd == 'h55) ? K_ER5 : K_IDLE;
          K_ER5: begin
            if (lo == 'h555 && dd == 'h10) begin e_c = 1; ph = K_CHIP; end
            else if (dd == 'h30) begin
              ph = K_LOAD; m_mask = 1 << sect_of(int'(wr_addr)); m_cnt = W;
            end else ph = K_IDLE;
          end
          K_SUSP: if (dd == 'h30) begin e_re = 1; ph = K_ERASE; end
                  else if (lo == 'h555 && dd == 'hAA) ph = K_SUN1;
          K_SUN1: ph = (lo == 'h2AA && dd == 'h55) ? K_SUN2 : K_SUSP;
          K_SUN2: ph = (lo == 'h555 && dd == 'hA0) ? K_SPDATA : K_SUSP;
          default: ;
        endcase
      end
      if (ph == K_IDLE) m_mask = 0;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done_flag) begin
      chk("R2", "prog_start", prog_start, e_p);
      if (e_p) begin
        chk("R2", "prog_addr", prog_addr, e_pa);
        chk("R2", "prog_data", prog_data, e_pd);
      end
      chk("R3", "chip_erase_start", chip_erase_start, e_c);
      chk("R6", "sect_erase_start", sect_erase_start, e_s);
      chk("R6", "sect_mask", sect_mask, m_mask);
      chk("R6", "window_open", window_open, ph == K_LOAD);
      chk("R8", "suspend_req", suspend_req, e_su);
      chk("R8", "abort_req", abort_req, e_ab);
      chk("R10", "resume_req", resume_req, e_re);
      chk("R5", "mode", mode, exp_mode());
    end
  end

  task automatic wr(input logic [18:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic fin();
    @(negedge clk); eng_done = 1'b1;
    @(negedge clk); eng_done = 1'b0;
  endtask

  task automatic unlock();
    wr(19'h00555, 8'hAA);
    wr(19'h002AA, 8'h55);
  endtask

  task automatic sect_seq(input logic [18:0] sa);
    unlock();
    wr(19'h00555, 8'h80);
    unlock();
    wr(sa, 8'h30);
  endtask

  task automatic finish_run();
    done_flag = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    #(5.0 * 100000);
    n_tests++; n_fail++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    finish_run();
  end

  initial begin
    idle(4);
    rst_n = 1'b1;
    idle(1);
    // R1 reset state
    chk("R1", "mode", mode, 0);
    chk("R1", "sect_mask", sect_mask, 0);
    chk("R1", "window_open", window_open, 0);
    chk("R1", "pulses", {prog_start, chip_erase_start, sect_erase_start, suspend_req, resume_req, abort_req}, 0);

    // R4 program with upper address bits set on command cycles
    wr(19'h7F555, 8'hAA);
    wr(19'h3A2AA, 8'h55);
    wr(19'h05555, 8'hA0);
    wr(19'h12345, 8'h5A);
    chk("R4", "prog_start upper bits", prog_start, 1);
    chk("R2", "prog_addr", prog_addr, 19'h12345);
    chk("R2", "prog_data", prog_data, 8'h5A);
    chk("R2", "mode busy", mode, 3);
    // R8 writes ignored while programming
    unlock();
    wr(19'h00555, 8'hA0);
    wr(19'h00000, 8'hF0);
    chk("R8", "mode during program", mode, 3);
    fin();
    chk("R12", "mode after done", mode, 0);

    // R5 broken prefix, then a lone code write
    wr(19'h00555, 8'hAA);
    wr(19'h002AB, 8'h55);
    wr(19'h00555, 8'hA0);
    wr(19'h00000, 8'h77);
    chk("R5", "no program after reject", prog_start, 0);
    chk("R5", "mode after reject", mode, 0);
    wr(19'h00000, 8'hF0);
    chk("R5", "F0 in read mode", mode, 0);

    // R11 identifier read
    unlock();
    wr(19'h40555, 8'h90);
    chk("R11", "mode id", mode, 1);
    rd_sel = 2'd0; idle(1); chk("R11", "mfr byte", id_byte, 8'hC2);
    rd_sel = 2'd1; idle(1); chk("R11", "dev byte", id_byte, 8'h45);
    rd_sel = 2'd2; idle(1); chk("R11", "other byte", id_byte, 8'h00);
    wr(19'h00000, 8'hF0);
    chk("R11", "F0 leaves id", mode, 0);

    // R3 chip erase, then R8 abort under fail
    unlock();
    wr(19'h00555, 8'h80);
    unlock();
    wr(19'h00555, 8'h10);
    chk("R3", "chip_erase_start", chip_erase_start, 1);
    wr(19'h00000, 8'hF0);
    chk("R8", "F0 ignored without fail", mode, 3);
    eng_fail = 1'b1;
    wr(19'h00000, 8'hF0);
    chk("R8", "abort_req", abort_req, 1);
    eng_fail = 1'b0;
    chk("R8", "mode after abort", mode, 0);

    // R6 multi-sector load with varied gaps
    sect_seq(19'h10000);
    chk("R6", "window open", window_open, 1);
    idle(3);
    wr(19'h7C000, 8'h30);
    idle(W - 2);
    wr(19'h78000, 8'h30);
    chk("R6", "mask three sectors", sect_mask, 11'h502);
    idle(W + 2);
    chk("R6", "window closed", window_open, 0);
    chk("R6", "mask kept while erasing", sect_mask, 11'h502);
    // R8 / R10 suspend, program while suspended, resume
    wr(19'h00000, 8'hB0);
    chk("R8", "suspend mode", mode, 2);
    unlock();
    wr(19'h00555, 8'hA0);
    wr(19'h20000, 8'h33);
    chk("R10", "prog in suspend", prog_start, 1);
    fin();
    chk("R10", "back to suspend", mode, 2);
    wr(19'h00555, 8'h80);
    chk("R10", "other code ignored", mode, 2);
    wr(19'h00000, 8'h30);
    chk("R10", "resume mode", mode, 3);
    fin();
    chk("R12", "mask cleared", sect_mask, 0);

    // R9 suspend inside the load window
    sect_seq(19'h7A000);
    idle(2);
    wr(19'h00000, 8'hB0);
    chk("R9", "start with suspend", {sect_erase_start, suspend_req}, 2'b11);
    chk("R9", "mode suspended", mode, 2);
    wr(19'h00000, 8'hF0);
    chk("R9", "F0 while suspended", mode, 2);
    wr(19'h00000, 8'h30);
    fin();

    // R7 foreign code inside the load window
    sect_seq(19'h70000);
    wr(19'h00555, 8'h80);
    chk("R7", "mode after reset code", mode, 0);
    chk("R7", "mask cleared", sect_mask, 0);
    idle(W + 2);
    chk("R7", "no erase started", window_open, 0);

    // R5 resume code outside suspension has no effect
    wr(19'h00000, 8'h30);
    chk("R5", "30h in read mode", {resume_req, mode}, 0);
    idle(3);
    finish_run();
  end
endmodule